// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive side of a packet DMA path that is organised as a ring of buffer slots. Software sets the ring length as the slot count minus one. It gives each slot a control word that holds the buffer size minus one and a request for a completion interrupt. An arriving frame comes in as a byte stream. The engine writes the frame into the slot named by its produce index, one byte per cycle at increasing offsets. When the frame ends it emits one status word for that slot and moves the produce index on, wrapping after the last slot.

Software takes a filled slot and hands it back by writing a new consume index. The engine reports the ring as empty when the two indices match. It reports the ring as full when one more advance of the produce index would reach the consume index. A frame that begins while the ring is full is dropped whole and raises an overrun flag. The status word carries the stored length minus one and two error flags, both inside the mask 0x1B800000. The consumer discards any frame that has either flag set.

Top module: `rxr_ring_engine`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame or consume write, `prod_idx` and `cons_idx` are 0, `ring_empty` is 1, `ring_full` is 0 and `overrun` is 0.
- R2: Byte k (counting from 0) of an accepted frame appears on `buf_we`/`buf_data` with `buf_slot` equal to the produce index and `buf_off` equal to k, on the clock edge after the byte is presented.
- R3: On the edge after the last byte of an accepted frame, `stat_we` pulses for one cycle. `stat_slot` is the old produce index, and `stat_word` bits 10:0 hold the number of stored bytes minus one, with all bits other than 10:0, 23 and 27 zero. `prod_idx` advances on that same edge and goes from `ring_last` back to 0.
- R4: If `rx_err` is high on any byte of an accepted frame, bit 23 of its status word is 1. Otherwise bit 23 is 0.
- R5: A slot's buffer size is bits 10:0 of its control word plus one. Bytes beyond that size are not written. Bit 27 of the status word is set, and the length field equals the buffer size minus one.
- R6: `ring_full` is 1 exactly when the produce index after its next advance would equal `cons_idx`. A frame whose first byte arrives while the ring is full produces no buffer write, no status write and no index change, and it sets `overrun`. An accepted consume write clears `overrun`.
- R7: `ring_empty` is 1 exactly when `prod_idx` equals `cons_idx`.
- R8: A consume write whose index is at most `ring_last` loads `cons_idx` on the next edge. A consume write above `ring_last` is ignored and leaves `cons_idx` and `overrun` unchanged.
- R9: `done_irq` pulses together with `stat_we` exactly when bit 31 of the finished slot's control word is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_last | input | IDX_W | Ring slot count minus one |
| ctl_wr_en | input | 1 | Write strobe for a slot control word |
| ctl_wr_slot | input | IDX_W | Slot whose control word is written |
| ctl_wr_data | input | 32 | Control word: 10:0 size minus one, 31 interrupt request |
| cons_wr_en | input | 1 | Software consume index write strobe |
| cons_wr_idx | input | IDX_W | New consume index |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | DATA_W | Frame byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| rx_err | input | 1 | Receive error on this byte |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_slot | output | IDX_W | Slot being written |
| buf_off | output | 11 | Byte offset within the slot |
| buf_data | output | DATA_W | Byte written |
| stat_we | output | 1 | Status word write strobe |
| stat_slot | output | IDX_W | Slot the status word belongs to |
| stat_word | output | 32 | Status: 10:0 length minus one, 23 frame error, 27 truncated |
| done_irq | output | 1 | Completion interrupt pulse |
| prod_idx | output | IDX_W | Produce index |
| cons_idx | output | IDX_W | Consume index |
| ring_empty | output | 1 | Nothing for software to take |
| ring_full | output | 1 | No free slot for a new frame |
| overrun | output | 1 | A frame was dropped because the ring was full |

## Verification
Every registered result is due one edge after its cause. A buffer write follows its byte by one edge. The status word, the interrupt pulse and the produce-index advance follow the last byte by one edge. A consume-index load follows its write strobe by one edge. The full and empty flags are combinational on the indices, so they change on the same edge as the indices. The bench drives inputs on falling edges and records buffer and status strobes on rising edges, when the registered outputs still hold the previous cycle's values. It compares indices and flags only at falling edges, at least one edge after the stimulus that moved them.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int LEN_W         = 11;
   localparam int CTL_IRQ_BIT   = 31;
   localparam int ST_FERR_BIT   = 23;
   localparam int ST_TRUNC_BIT  = 27;
   localparam logic [31:0] ST_ERR_MASK = 32'h1B80_0000;

   function automatic logic [31:0] build_status(input logic [LEN_W-1:0] len_m1,
                                                input logic ferr,
                                                input logic trunc);
      logic [31:0] w;
      w = '0;
      w[LEN_W-1:0]  = len_m1;
      w[ST_FERR_BIT]  = ferr;
      w[ST_TRUNC_BIT] = trunc;
      return w;
   endfunction
endpackage

// File: rtl/rxr_ctl_store.sv
module rxr_ctl_store
   import rxr_pkg::*;
#(
   parameter int SLOTS  = 8,
   parameter int IDX_W  = 3,
   parameter bit IRQ_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_slot,
   input  logic [31:0]      wr_data,
   input  logic [IDX_W-1:0] rd_slot,
   output logic [LEN_W-1:0] rd_size_m1,
   output logic             rd_irq
);
   logic [LEN_W-1:0] size_q [SLOTS];
   logic [SLOTS-1:0] irq_q;

   always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
         if (!rst_n)
            size_q[s] <= '0;
         else if (wr_en && wr_slot == IDX_W'(s))
            size_q[s] <= wr_data[LEN_W-1:0];
      end
   end

   if (IRQ_EN) begin : g_irq
      always_ff @(posedge clk) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (!rst_n)
               irq_q[s] <= 1'b0;
            else if (wr_en && wr_slot == IDX_W'(s))
               irq_q[s] <= wr_data[CTL_IRQ_BIT];
         end
      end
   end else begin : g_noirq
      assign irq_q = '0;
   end

   always_comb begin
      rd_size_m1 = '0;
      rd_irq     = 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
         if (rd_slot == IDX_W'(s)) begin
            rd_size_m1 = size_q[s];
            rd_irq     = irq_q[s];
         end
      end
   end
endmodule

// File: rtl/rxr_index.sv
module rxr_index #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ring_last,
   input  logic             adv,
   input  logic             drop,
   input  logic             cons_wr_en,
   input  logic [IDX_W-1:0] cons_wr_idx,
   output logic [IDX_W-1:0] prod,
   output logic [IDX_W-1:0] cons,
   output logic             full,
   output logic             empty,
   output logic             overrun
);
   logic [IDX_W-1:0] prod_nxt;
   logic             cons_ok;

   always_comb begin
      prod_nxt = (prod >= ring_last) ? '0 : prod + 1'b1;
      full     = (prod_nxt == cons);
      empty    = (prod == cons);
      cons_ok  = cons_wr_en && (cons_wr_idx <= ring_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod    <= '0;
         cons    <= '0;
         overrun <= 1'b0;
      end else begin
         if (adv)
            prod <= prod_nxt;
         if (cons_ok)
            cons <= cons_wr_idx;
         if (drop)
            overrun <= 1'b1;
         else if (cons_ok)
            overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
   import rxr_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   input  logic              rx_err,
   input  logic              full,
   input  logic [IDX_W-1:0]  prod,
   input  logic [LEN_W-1:0]  size_m1,
   input  logic              irq_req,
   output logic              adv,
   output logic              drop,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_slot,
   output logic [LEN_W-1:0]  buf_off,
   output logic [DATA_W-1:0] buf_data,
   output logic              stat_we,
   output logic [IDX_W-1:0]  stat_slot,
   output logic [31:0]       stat_word,
   output logic              done_irq
);
   localparam int CNT_W = LEN_W + 1;

   logic             in_frame, dropping, ferr_q, trunc_q;
   logic [CNT_W-1:0] cnt_q, offset;
   logic             first, take, fits, ferr_acc, trunc_acc;
   logic [LEN_W-1:0] len_m1;

   always_comb begin
      first     = rx_valid && !in_frame;
      take      = rx_valid && (in_frame ? !dropping : !full);
      drop      = first && full;
      adv       = take && rx_last;
      offset    = in_frame ? cnt_q : '0;
      fits      = offset <= {1'b0, size_m1};
      ferr_acc  = (in_frame && ferr_q) || rx_err;
      trunc_acc = (in_frame && trunc_q) || !fits;
      len_m1    = fits ? offset[LEN_W-1:0] : size_m1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         dropping  <= 1'b0;
         ferr_q    <= 1'b0;
         trunc_q   <= 1'b0;
         cnt_q     <= '0;
         buf_we    <= 1'b0;
         buf_slot  <= '0;
         buf_off   <= '0;
         buf_data  <= '0;
         stat_we   <= 1'b0;
         stat_slot <= '0;
         stat_word <= '0;
         done_irq  <= 1'b0;
      end else begin
         buf_we   <= take && fits;
         stat_we  <= adv;
         done_irq <= adv && irq_req;
         if (rx_valid) begin
            in_frame <= !rx_last;
            if (rx_last)
               dropping <= 1'b0;
            else if (first)
               dropping <= full;
         end
         if (take) begin
            ferr_q  <= ferr_acc;
            trunc_q <= trunc_acc;
            if (fits) begin
               cnt_q    <= offset + 1'b1;
               buf_slot <= prod;
               buf_off  <= offset[LEN_W-1:0];
               buf_data <= rx_data;
            end else begin
               cnt_q <= offset;
            end
         end
         if (adv) begin
            stat_slot <= prod;
            stat_word <= build_status(len_m1, ferr_acc, trunc_acc);
         end
      end
   end
endmodule

// File: rtl/rxr_ring_engine.sv
module rxr_ring_engine
   import rxr_pkg::*;
#(
   parameter int SLOTS_MAX = 8,
   parameter int DATA_W    = 8,
   parameter bit IRQ_EN    = 1'b1,
   localparam int IDX_W    = $clog2(SLOTS_MAX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  ring_last,
   input  logic              ctl_wr_en,
   input  logic [IDX_W-1:0]  ctl_wr_slot,
   input  logic [31:0]       ctl_wr_data,
   input  logic              cons_wr_en,
   input  logic [IDX_W-1:0]  cons_wr_idx,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_last,
   input  logic              rx_err,
   output logic              buf_we,
   output logic [IDX_W-1:0]  buf_slot,
   output logic [LEN_W-1:0]  buf_off,
   output logic [DATA_W-1:0] buf_data,
   output logic              stat_we,
   output logic [IDX_W-1:0]  stat_slot,
   output logic [31:0]       stat_word,
   output logic              done_irq,
   output logic [IDX_W-1:0]  prod_idx,
   output logic [IDX_W-1:0]  cons_idx,
   output logic              ring_empty,
   output logic              ring_full,
   output logic              overrun
);
   initial begin
      assert (SLOTS_MAX >= 2 && SLOTS_MAX == (1 << IDX_W))
         else $error("SLOTS_MAX must be a power of two of at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be positive");
   end

   logic [LEN_W-1:0] size_m1;
   logic             irq_req, adv, drop;

   rxr_ctl_store #(.SLOTS(SLOTS_MAX), .IDX_W(IDX_W), .IRQ_EN(IRQ_EN)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(ctl_wr_en), .wr_slot(ctl_wr_slot), .wr_data(ctl_wr_data),
      .rd_slot(prod_idx), .rd_size_m1(size_m1), .rd_irq(irq_req)
   );

   rxr_index #(.IDX_W(IDX_W)) u_idx (
      .clk(clk), .rst_n(rst_n), .ring_last(ring_last),
      .adv(adv), .drop(drop),
      .cons_wr_en(cons_wr_en), .cons_wr_idx(cons_wr_idx),
      .prod(prod_idx), .cons(cons_idx),
      .full(ring_full), .empty(ring_empty), .overrun(overrun)
   );

   rxr_frame #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_frm (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_err(rx_err),
      .full(ring_full), .prod(prod_idx), .size_m1(size_m1), .irq_req(irq_req),
      .adv(adv), .drop(drop),
      .buf_we(buf_we), .buf_slot(buf_slot), .buf_off(buf_off), .buf_data(buf_data),
      .stat_we(stat_we), .stat_slot(stat_slot), .stat_word(stat_word),
      .done_irq(done_irq)
   );
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [IDX_W-1:0] ring_last,
   input logic             cons_wr_en,
   input logic             stat_we,
   input logic [IDX_W-1:0] stat_slot,
   input logic [31:0]      stat_word,
   input logic             done_irq,
   input logic [IDX_W-1:0] prod_idx,
   input logic [IDX_W-1:0] cons_idx,
   input logic             ring_empty,
   input logic             ring_full
);
   // R3
   stat_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |-> stat_slot == $past(prod_idx));
   // R3
   prod_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_idx != $past(prod_idx)) |-> stat_we);
   // R3
   stat_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we |-> (stat_word & 32'hF77F_F800) == 32'h0);
   // R9
   irq_with_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> stat_we);
   // R6
   full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ring_last != '0) |-> !(ring_full && ring_empty));
   // R8
   cons_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cons_idx != $past(cons_idx)) |-> $past(cons_wr_en));
endmodule

bind rxr_ring_engine rxr_ring_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/test_rxr_ring_engine.sv
`timescale 1ns/1ps
module test_rxr_ring_engine;
   localparam int IDX_W = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [IDX_W-1:0] ring_last = 3'd3;
   logic ctl_wr_en = 0; logic [IDX_W-1:0] ctl_wr_slot = 0; logic [31:0] ctl_wr_data = 0;
   logic cons_wr_en = 0; logic [IDX_W-1:0] cons_wr_idx = 0;
   logic rx_valid = 0, rx_last = 0, rx_err = 0; logic [7:0] rx_data = 0;
   logic buf_we, stat_we, done_irq, ring_empty, ring_full, overrun;
   logic [IDX_W-1:0] buf_slot, stat_slot, prod_idx, cons_idx;
   logic [10:0] buf_off; logic [7:0] buf_data; logic [31:0] stat_word;

   int checks = 0, fails = 0;

   always #4 clk = ~clk;

   rxr_ring_engine i_rxr_ring_engine (.*);

   logic [7:0] cap_mem [0:7][0:63];
   int cap_wr_cnt = 0, cap_stat_cnt = 0, cap_irq_cnt = 0;
   logic [31:0] cap_stat = 0; logic [IDX_W-1:0] cap_stat_slot = 0;

   always @(posedge clk) begin
      if (buf_we) begin
         cap_wr_cnt++;
         if (buf_off < 64) cap_mem[buf_slot][buf_off[5:0]] = buf_data;
      end
      if (stat_we) begin
         cap_stat_cnt++; cap_stat = stat_word; cap_stat_slot = stat_slot;
      end
      if (done_irq) cap_irq_cnt++;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_caps();
      cap_wr_cnt = 0; cap_stat_cnt = 0; cap_irq_cnt = 0;
   endtask

   task automatic write_ctl(input int slot, input logic [31:0] w);
      @(negedge clk); ctl_wr_en = 1; ctl_wr_slot = IDX_W'(slot); ctl_wr_data = w;
      @(negedge clk); ctl_wr_en = 0;
   endtask

   task automatic write_cons(input int idx);
      @(negedge clk); cons_wr_en = 1; cons_wr_idx = IDX_W'(idx);
      @(negedge clk); cons_wr_en = 0;
   endtask

   task automatic send_frame(input int n, input logic [7:0] base, input int err_at);
      clear_caps();
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1; rx_data = base + 8'(i); rx_last = (i == n-1); rx_err = (i == err_at);
      end
      @(negedge clk); rx_valid = 0; rx_last = 0; rx_err = 0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 prod", prod_idx, 0); chk("R1 cons", cons_idx, 0);
      chk("R1 empty", ring_empty, 1); chk("R1 full", ring_full, 0);
      chk("R1 overrun", overrun, 0); chk("R1 stat_we", stat_we, 0);
   endtask

   task automatic t_plain();
      send_frame(10, 8'h10, -1);
      chk("R2 write count", cap_wr_cnt, 10);
      for (int i = 0; i < 10; i++) chk("R2 byte", cap_mem[0][i], 8'h10 + i);
      chk("R3 status count", cap_stat_cnt, 1);
      chk("R3 status word", cap_stat, 32'h0000_0009);
      chk("R3 status slot", cap_stat_slot, 0);
      chk("R3 prod advance", prod_idx, 1);
      chk("R7 not empty", ring_empty, 0);
      chk("R9 no irq", cap_irq_cnt, 0);
   endtask

   task automatic t_error();
      send_frame(5, 8'h40, 2);
      chk("R4 status err", cap_stat, 32'h0080_0004);
      chk("R4 slot", cap_stat_slot, 1);
      chk("R2 byte slot1", cap_mem[1][4], 8'h44);
      chk("R9 irq", cap_irq_cnt, 1);
   endtask

   task automatic t_trunc();
      send_frame(12, 8'h80, -1);
      chk("R5 writes", cap_wr_cnt, 8);
      chk("R5 status", cap_stat, 32'h0800_0007);
      chk("R5 last kept", cap_mem[2][7], 8'h87);
      chk("R3 prod 3", prod_idx, 3);
   endtask

   task automatic t_full();
      chk("R6 full", ring_full, 1);
      send_frame(3, 8'hC0, -1);
      chk("R6 no writes", cap_wr_cnt, 0);
      chk("R6 no status", cap_stat_cnt, 0);
      chk("R6 overrun", overrun, 1);
      chk("R6 prod held", prod_idx, 3);
   endtask

   task automatic t_cons_range();
      write_cons(5);
      @(negedge clk);
      chk("R8 ignored cons", cons_idx, 0);
      chk("R8 overrun kept", overrun, 1);
      write_cons(1);
      @(negedge clk);
      chk("R8 cons loaded", cons_idx, 1);
      chk("R6 overrun cleared", overrun, 0);
      chk("R6 not full", ring_full, 0);
   endtask

   task automatic t_wrap();
      send_frame(1, 8'hE5, -1);
      chk("R3 single byte", cap_stat, 32'h0);
      chk("R3 slot3", cap_stat_slot, 3);
      chk("R2 byte slot3", cap_mem[3][0], 8'hE5);
      chk("R3 wrap", prod_idx, 0);
      write_cons(0);
      @(negedge clk);
      chk("R7 empty", ring_empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      write_ctl(0, 32'd63);
      write_ctl(1, 32'h8000_003F);
      write_ctl(2, 32'd7);
      write_ctl(3, 32'd63);
      t_plain();
      t_error();
      t_trunc();
      t_full();
      t_cons_range();
      t_wrap();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #100000;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule